// File: doc/BRIEF.md
# Register-Controlled ADC Conversion Sequencer

This block sits between a processor register bus and a multi-channel successive-approximation converter whose analog side has already been reduced to digital words. Software programs one 32-bit control word that picks a channel, a reference, a clock divider and an interrupt policy, and then sets a start bit. The block times the conversion with a prescaled counter. When the time is up it posts a 10-bit result, the channel sample's ratio to the chosen reference, saturated at full scale, into a read-only data word.

The conversion length is 20 prescaled ticks, and each tick is 2*(divider+1) input clocks. The result is computed in the background by a short restoring divider that always finishes before the timer expires. Completion can raise an interrupt status bit and a level interrupt line. Software clears both by writing one to the status bit. A soft-reset bit in the same control word returns the whole block to its power-on state.

Top module: `adc_ctrl`

## Requirements
- R1: After reset the control word reads 0x000C0001, the data word reads 0 and `irq` is low.
- R2: A read with `bus_addr`=0x0 returns control and `bus_addr`=0x4 returns data in `bus_rdata` one clock after the request. Any other address, unaligned ones included, reads 0.
- R3: Writes to the data address or to any unmapped address change no register.
- R4: Control bits 8:1 hold the divider D. A started conversion keeps start/busy bit 14 set for exactly 40*(D+1) clocks and then clears it.
- R5: A conversion starts only when a control write has enable bit 17 and bit 14 set while bit 14 was clear before. A write that sets bit 14 while it is already set neither starts nor restarts the timer.
- R6: The result is min(1023, floor(sample*1024/ref)). The sample is that of the channel in bits 27:24, and ref is `ref_int` when bit 19 is 1 and `ref_ext` when it is 0. All three are taken when the conversion starts.
- R7: On completion with interrupt-enable bit 21 set, status bit 18 is set and `irq` goes high on the same edge that clears bit 14. With bit 21 clear, neither changes.
- R8: Writing 1 to bit 18 clears it and drops `irq`. Writing 0 to bit 18 leaves its value and `irq` unchanged.
- R9: A control write with bit 17 set and bit 14 clear cancels a running conversion: data keeps its value and no interrupt follows.
- R10: A control write with bit 16 set ignores every other written bit. It restores the reset values of R1 and cancels any running conversion.
- R11: If the channel field is 8 or above, completion leaves data unchanged, raises no interrupt and leaves bit 14 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the request |
| ch_samples | input | 256 | Eight 32-bit channel samples, channel n at bits 32n+31:32n |
| ref_int | input | 32 | Internal reference value, nonzero |
| ref_ext | input | 32 | External reference value, nonzero |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that both reference inputs are nonzero whenever a conversion starts, because the divider's remainder bound relies on a positive divisor. They also assume that the sample and reference inputs, although they are only taken at the start edge, do not change in the same cycle as a start write. The stimulus draws every reference from a range that starts at 1 and updates samples and references only between bus accesses, when the block is idle. Random samples reach up to twice the reference, so both the exact quotient and the saturated value occur often.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  // control word field positions (behavioural: software decodes them)
  localparam int CTL_CH_LO  = 24;
  localparam int CTL_CH_W   = 4;
  localparam int CTL_IE     = 21;
  localparam int CTL_RS     = 19;
  localparam int CTL_IF     = 18;
  localparam int CTL_EN     = 17;
  localparam int CTL_SR     = 16;
  localparam int CTL_GO     = 14;
  localparam int CTL_DIV_LO = 1;
  localparam logic [31:0] CTL_RST_VAL = 32'h000C_0001;
  localparam logic [11:0] OFS_CTL = 12'h000;
  localparam logic [11:0] OFS_DAT = 12'h004;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int DIV_W = 8,
  parameter int TICKS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [DIV_W-1:0] div,
  output logic             done
);
  localparam int TC_W = $clog2(TICKS);

  logic             running;
  logic [DIV_W:0]   pc;
  logic [TC_W-1:0]  tc;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   plim;

  assign plim = {div_q, 1'b1};  // 2*(div+1)-1
  assign done = running && (pc == plim) && (tc == TC_W'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pc      <= '0;
      tc      <= '0;
      div_q   <= '0;
    end else if (start) begin
      running <= 1'b1;
      pc      <= '0;
      tc      <= '0;
      div_q   <= div;
    end else if (stop) begin
      running <= 1'b0;
    end else if (running) begin
      if (pc == plim) begin
        pc <= '0;
        if (tc == TC_W'(TICKS - 1)) running <= 1'b0;
        else tc <= tc + TC_W'(1);
      end else begin
        pc <= pc + (DIV_W+1)'(1);
      end
    end
  end

  // length check: elapsed clocks since start when done fires
  logic [31:0] elapsed;
  logic [31:0] len_m1;
  assign len_m1 = 32'(TICKS) * (32'(div_q) + 32'd1) * 32'd2 - 32'd1;
  always_ff @(posedge clk) begin
    if (rst || start) elapsed <= '0;
    else if (running) elapsed <= elapsed + 32'd1;
  end

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> elapsed == len_m1);  // R4
endmodule

// File: rtl/adc_ratio_div.sv
module adc_ratio_div #(
  parameter int W     = 32,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     num,
  input  logic [W-1:0]     den,
  output logic             ready,
  output logic [RES_W-1:0] quo
);
  localparam int CW = $clog2(RES_W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  rem;
  logic [W-1:0]  den_q;
  logic [W:0]    trial;

  assign ready = (cnt == '0);
  assign trial = {rem, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      rem   <= '0;
      den_q <= '0;
      quo   <= '0;
    end else if (start) begin
      den_q <= den;
      if (num >= den) begin
        quo <= '1;
        cnt <= '0;
      end else begin
        rem <= num;
        quo <= '0;
        cnt <= CW'(RES_W);
      end
    end else if (cnt != '0) begin
      if (trial >= {1'b0, den_q}) begin
        rem <= W'(trial - {1'b0, den_q});
        quo <= {quo[RES_W-2:0], 1'b1};
      end else begin
        rem <= trial[W-1:0];
        quo <= {quo[RES_W-2:0], 1'b0};
      end
      cnt <= cnt - CW'(1);
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> rem < den_q);  // R6
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (start && num >= den) |=> (ready && quo == '1));  // R6
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DW         = 32,
  parameter int RES_W      = 10,
  parameter int DIV_W      = 8,
  parameter int CONV_TICKS = 20,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH*DW-1:0] ch_samples,
  input  logic [DW-1:0]     ref_int,
  input  logic [DW-1:0]     ref_ext,
  output logic              irq
);
  localparam int CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [31:0]      ctrl_q, ctrl_d;
  logic [RES_W-1:0] data_q, data_d;
  logic             irq_q, irq_d;
  logic [31:0]      rdata_q;

  // unpack channel samples
  logic [DW-1:0] smp [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign smp[g] = ch_samples[g*DW +: DW];
  end

  logic wr_ctrl, soft_rst_w, start_w, abort_w;
  assign wr_ctrl    = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CTL));
  assign soft_rst_w = wr_ctrl && bus_wdata[CTL_SR];
  assign start_w    = wr_ctrl && !bus_wdata[CTL_SR] && bus_wdata[CTL_EN]
                      && bus_wdata[CTL_GO] && !ctrl_q[CTL_GO];
  assign abort_w    = wr_ctrl && !bus_wdata[CTL_SR] && bus_wdata[CTL_EN]
                      && !bus_wdata[CTL_GO];

  logic [CTL_CH_W-1:0] ch_sel;
  logic                ch_ok, chan_ok_q;
  logic [DW-1:0]       den_sel;
  assign ch_sel  = bus_wdata[CTL_CH_LO +: CTL_CH_W];
  assign ch_ok   = 32'(ch_sel) < NCH;
  assign den_sel = bus_wdata[CTL_RS] ? ref_int : ref_ext;

  always_ff @(posedge clk) begin
    if (rst || soft_rst_w) chan_ok_q <= 1'b0;
    else if (start_w)      chan_ok_q <= ch_ok;
  end

  logic tmr_done, div_ready;
  logic [RES_W-1:0] div_quo;

  adc_conv_timer #(.DIV_W(DIV_W), .TICKS(CONV_TICKS)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (start_w),
    .stop  (soft_rst_w || abort_w),
    .div   (bus_wdata[CTL_DIV_LO +: DIV_W]),
    .done  (tmr_done)
  );

  adc_ratio_div #(.W(DW), .RES_W(RES_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (start_w),
    .num   (ch_ok ? smp[ch_sel[CH_IDX_W-1:0]] : '0),
    .den   (den_sel),
    .ready (div_ready),
    .quo   (div_quo)
  );

  logic complete;
  assign complete = tmr_done && chan_ok_q && !soft_rst_w && !abort_w && !start_w;

  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    irq_d  = irq_q;
    if (soft_rst_w) begin
      ctrl_d = CTL_RST_VAL;
      data_d = '0;
      irq_d  = 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_d = bus_wdata;
        ctrl_d[CTL_IF] = bus_wdata[CTL_IF] ? 1'b0 : ctrl_q[CTL_IF];
        if (bus_wdata[CTL_IF]) irq_d = 1'b0;
      end
      if (complete) begin
        data_d = div_quo;
        ctrl_d[CTL_GO] = 1'b0;
        if (ctrl_d[CTL_IE]) begin
          ctrl_d[CTL_IF] = 1'b1;
          irq_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTL_RST_VAL;
      data_q  <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
      irq_q  <= irq_d;
      if (bus_valid && !bus_write) begin
        if (bus_addr == ADDR_W'(OFS_CTL))      rdata_q <= ctrl_q;
        else if (bus_addr == ADDR_W'(OFS_DAT)) rdata_q <= 32'(data_q);
        else                                   rdata_q <= '0;
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(tmr_done));  // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(tmr_done) && !$past(soft_rst_w)) |-> $stable(data_q));  // R3
  AST_DIV_FIRST: assert property (@(posedge clk) disable iff (rst)
    tmr_done |-> div_ready);  // R6
  AST_BADCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    (tmr_done && !chan_ok_q && !wr_ctrl && ctrl_q[CTL_GO]) |=> ctrl_q[CTL_GO]);  // R11
endmodule

// File: tb/sim_adc_ctrl.sv
module sim_adc_ctrl;
  logic         clk = 1'b0;
  logic         rst;
  logic         bus_valid, bus_write;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [255:0] ch_samples;
  logic [31:0]  ref_int, ref_ext;
  logic         irq;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_data = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;  // 125 MHz

  adc_ctrl u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_samples(ch_samples), .ref_int(ref_int), .ref_ext(ref_ext), .irq(irq)
  );

  function automatic logic [31:0] ratio(input logic [31:0] s, input logic [31:0] r);
    logic [63:0] q;
    if (s >= r) return 32'd1023;
    q = ({32'd0, s} * 64'd1024) / {32'd0, r};
    return q[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  // full conversion on a valid channel; flag cleared by the start write
  task automatic conv(input int ch, input bit ie, input bit rs, input int dv);
    logic [31:0] w, r, e;
    int n;
    w = (32'(ch) << 24) | (32'(ie) << 21) | (32'(rs) << 19) | (32'd1 << 18)
        | (32'd1 << 17) | (32'd1 << 14) | (32'(dv) << 1);
    n = 40 * (dv + 1);
    e = ratio(ch_samples[ch*32 +: 32], rs ? ref_int : ref_ext);
    wr(12'h0, w);
    repeat (n - 1) @(negedge clk);
    chk("R7 irq low before end", 32'(irq), 0);
    rd(12'h0, r);
    chk("R4 busy at last clock", 32'(r[14]), 1);
    rd(12'h0, r);
    chk("R4 R7 control after end", r, (w & ~(32'd1 << 18) & ~(32'd1 << 14)) | (32'(ie) << 18));
    chk("R7 irq level", 32'(irq), 32'(ie));
    rd(12'h4, r);
    chk("R6 result", r, e);
    exp_data = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h1234_abcd));
    rst = 1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    ch_samples = '0; ref_int = 32'd2000000; ref_ext = 32'd3300000;
    for (int i = 0; i < 8; i++) ch_samples[i*32 +: 32] = 32'(i * 250000 + 7);
    repeat (3) @(negedge clk);
    rst = 0;

    // R1
    chk("R1 irq", 32'(irq), 0);
    rd(12'h0, rv); chk("R1 control", rv, 32'h000C0001);
    rd(12'h4, rv); chk("R1 data", rv, 0);
    // R2 / R3
    wr(12'h4, 32'hFFFF_FFFF);
    rd(12'h4, rv); chk("R3 data write ignored", rv, 0);
    rd(12'h8, rv); chk("R2 unmapped read", rv, 0);
    rd(12'h1, rv); chk("R2 unaligned read", rv, 0);
    wr(12'h8, 32'hFFFF_FFFF);
    rd(12'h0, rv); chk("R3 unmapped write", rv, 32'h000C0001);
    // R8 on reset-set flag
    wr(12'h0, 32'h0);
    rd(12'h0, rv); chk("R8 write 0 keeps flag", rv, 32'h0004_0000);
    wr(12'h0, 32'h0004_0000);
    rd(12'h0, rv); chk("R8 write 1 clears flag", rv, 0);
    // R5 disabled start, then no restart on already-set bit
    wr(12'h0, 32'h0000_4000);
    repeat (100) @(negedge clk);
    rd(12'h0, rv); chk("R5 no start when disabled", rv, 32'h0000_4000);
    rd(12'h4, rv); chk("R5 data untouched", rv, 0);
    wr(12'h0, 32'h0002_4000);
    repeat (60) @(negedge clk);
    rd(12'h0, rv); chk("R5 no start when bit already set", rv, 32'h0002_4000);
    wr(12'h0, 32'h0002_0000);
    rd(12'h0, rv); chk("R9 clear busy", rv, 32'h0002_0000);

    // directed clamp corners (R6)
    ref_ext = 32'd1000; ch_samples[3*32 +: 32] = 32'd1000;
    conv(3, 1'b0, 1'b0, 0);
    ch_samples[3*32 +: 32] = 32'd999;
    conv(3, 1'b1, 1'b0, 0);
    ref_int = 32'd1; ch_samples[5*32 +: 32] = 32'hFFFF_FFFF;
    conv(5, 1'b0, 1'b1, 1);

    // random conversions (R4 R6 R7)
    for (int k = 0; k < 40; k++) begin
      ref_int = ($urandom % 5000000) + 1;
      ref_ext = ($urandom % 5000000) + 1;
      for (int i = 0; i < 8; i++)
        ch_samples[i*32 +: 32] = $urandom % (2 * ((i % 2) ? ref_int : ref_ext));
      conv(int'($urandom % 8), 1'($urandom), 1'($urandom), int'($urandom % 4));
    end

    // R5 rewriting start while busy does not restart
    ref_ext = 32'd4000; ch_samples[1*32 +: 32] = 32'd1234;
    w = (32'd1 << 24) | (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 14) | (32'd1 << 1);
    wr(12'h0, w);
    repeat (4) @(negedge clk);
    wr(12'h0, w & ~(32'd1 << 18));
    repeat (80 - 1 - 5) @(negedge clk);
    rd(12'h0, rv); chk("R5 busy at original last clock", 32'(rv[14]), 1);
    rd(12'h0, rv); chk("R5 ends on original schedule", 32'(rv[14]), 0);
    rd(12'h4, rv); chk("R5 result", rv, ratio(32'd1234, 32'd4000));
    exp_data = ratio(32'd1234, 32'd4000);

    // R9 abort
    ch_samples[1*32 +: 32] = 32'd3999;
    wr(12'h0, (32'd1 << 24) | (32'd1 << 21) | (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 14));
    repeat (10) @(negedge clk);
    wr(12'h0, 32'h0002_0000);
    repeat (60) @(negedge clk);
    rd(12'h0, rv); chk("R9 control after abort", rv, 32'h0002_0000);
    rd(12'h4, rv); chk("R9 data kept", rv, exp_data);
    chk("R9 no irq", 32'(irq), 0);

    // R8 with raised line
    conv(1, 1'b1, 1'b0, 0);
    wr(12'h0, 32'h0002_0000);
    chk("R8 write 0 keeps irq", 32'(irq), 1);
    rd(12'h0, rv); chk("R8 flag kept", rv, 32'h0006_0000);
    wr(12'h0, 32'h0006_0000);
    chk("R8 write 1 drops irq", 32'(irq), 0);
    rd(12'h0, rv); chk("R8 flag cleared", rv, 32'h0002_0000);

    // R11 invalid channel
    w = (32'd9 << 24) | (32'd1 << 21) | (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 14);
    wr(12'h0, w);
    repeat (60) @(negedge clk);
    rd(12'h0, rv); chk("R11 busy stays", rv, w & ~(32'd1 << 18));
    rd(12'h4, rv); chk("R11 data kept", rv, exp_data);
    chk("R11 no irq", 32'(irq), 0);
    wr(12'h0, 32'h0006_0000);

    // R10 soft reset cancels pending conversion
    ch_samples[2*32 +: 32] = 32'd777; ref_ext = 32'd1000;
    wr(12'h0, (32'd2 << 24) | (32'd1 << 21) | (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 14));
    repeat (5) @(negedge clk);
    wr(12'h0, 32'hFFFF_FFFF);
    rd(12'h0, rv); chk("R10 control reset", rv, 32'h000C0001);
    rd(12'h4, rv); chk("R10 data reset", rv, 0);
    repeat (60) @(negedge clk);
    chk("R10 no irq after cancel", 32'(irq), 0);
    rd(12'h4, rv); chk("R10 data stays 0", rv, 0);
    rd(12'h0, rv); chk("R10 control stays", rv, 32'h000C0001);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule